// File: doc/BRIEF.md
# Eight-point accurate integer forward DCT

This block computes a one-dimensional, eight-point forward discrete cosine transform on signed 16-bit integers. It is the arithmetic core used twice in a separable 2-D transform: once over rows and once over columns. Eight samples and a pass flag arrive together under a valid/ready handshake. Eight coefficients leave, in natural index order, with a valid strobe two clock edges later.

The datapath first forms the usual sum/difference butterfly with 16-bit wraparound arithmetic. The even half yields coefficients 0 and 4 directly from sums. Coefficients 2 and 6 and the four odd coefficients come from pairs of fixed-point products with 13 fractional bits. The rotations are folded so that every product pair shares a combined constant.

The pass flag picks the scaling. On the row pass the DC-style outputs are scaled up by two bits and the product outputs are descaled by 11 bits. On the column pass the DC-style outputs are rounded down by two bits and the product outputs are descaled by 15 bits. Product results are rounded to nearest and saturated to the signed 16-bit range.

Top module: `fdct8_core`

## Requirements
- R1: While `rst` is high, `in_ready` is 0. On the edge after `rst` is sampled high, `out_valid` is 0 and `out_data` is all zeros.
- R2: With `rst` low, `in_ready` is 1. A vector accepted at clock edge k appears on `out_data` with `out_valid` high right after edge k+2. A cycle without `in_valid` gives a cycle with `out_valid` low two edges later.
- R3: The first-stage terms are s_i = x_i + x_(7-i) and d_i = x_i − x_(7-i) for i = 0..3, taken modulo 2^16 as signed values. All sums and differences built from them are also 16-bit wraparound.
- R4: Let a = s0 + s3 and b = s1 + s2. Then y0 = a + b and y4 = a − b. On the row pass each is shifted left by 2 within 16 bits. On the column pass 2 is added within 16 bits and the result is shifted right arithmetically by 2.
- R5: Let c = s0 − s3 and e = s1 − s2. Then y2 comes from c·10703 + e·4433, and y6 comes from c·4433 − e·10704.
- R6: Let p = d3 + d1 and q = d2 + d0. Let P = −6436·p + 9633·q and Q = 9633·p + 6437·q. The odd outputs are built from these sums: y7 = −4927·d3 − 7373·d0 + P; y5 = −4176·d2 − 20995·d1 + Q; y3 = −20995·d2 + 4177·d1 + P; y1 = −7373·d3 + 4926·d0 + Q. All use 32-bit wraparound.
- R7: The 32-bit results for y1, y2, y3, y5, y6 and y7 are rounded by adding 2^(n−1) and shifted right arithmetically by n. n is 11 on the row pass and 15 on the column pass.
- R8: After descaling, y1, y2, y3, y5, y6 and y7 saturate to the range −32768..32767.
- R9: `in_pass` is 0 for the row pass and 1 for the column pass. It is captured with the vector it accompanies. Back-to-back vectors with different pass flags are each scaled by their own flag.
- R10: Sample x_i is taken from `in_data[16i+15:16i]`, and coefficient y_i is placed at `out_data[16i+15:16i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector and pass flag are present |
| in_ready | output | 1 | Block accepts a vector this cycle |
| in_pass | input | 1 | 0 = row-pass scaling, 1 = column-pass scaling |
| in_data | input | 128 | Eight signed 16-bit samples, lane i at bits 16i+15:16i |
| out_valid | output | 1 | Coefficients on out_data are new this cycle |
| out_data | output | 128 | Eight signed 16-bit coefficients, lane i at bits 16i+15:16i |

## Verification
The only state is one register stage of butterfly terms and a pass bit, followed by the output register. Any corruption therefore shows up in the very vector that passes through, exactly two edges after it is accepted.

A bad butterfly term spreads into several lanes at once. A wrong or stale pass bit changes lanes 0 and 4 by roughly a factor of sixteen and shifts every product lane by four bits. A slip in the valid chain shows up as a missing or extra `out_valid` pulse one edge later.

Streams that change the pass flag on every vector, together with inputs chosen to wrap the butterfly or saturate the descale, make each of these faults visible within a single vector.

// File: rtl/fdct8_core.sv
module fdct8_core #(
  parameter int SAMPLE_W   = 16,
  parameter int ACC_W      = 32,
  parameter int CONST_BITS = 13,
  parameter int PASS1_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_pass,
  input  logic [8*SAMPLE_W-1:0] in_data,
  output logic                  out_valid,
  output logic [8*SAMPLE_W-1:0] out_data
);
  localparam int VEC_W  = 8 * SAMPLE_W;
  localparam int SH_ROW = CONST_BITS - PASS1_BITS;
  localparam int SH_COL = CONST_BITS + PASS1_BITS;

  localparam int C0298 = 2446;
  localparam int C0390 = 3196;
  localparam int C0541 = 4433;
  localparam int C0765 = 6270;
  localparam int C0899 = 7373;
  localparam int C1175 = 9633;
  localparam int C1501 = 12299;
  localparam int C1847 = 15137;
  localparam int C1961 = 16069;
  localparam int C2053 = 16819;
  localparam int C2562 = 20995;
  localparam int C3072 = 25172;

  typedef logic signed [SAMPLE_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0]    acc_t;

  localparam acc_t SAT_HI = acc_t'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam acc_t SAT_LO = acc_t'(-(64'sd1 <<< (SAMPLE_W - 1)));
  localparam acc_t RND_ROW = acc_t'(64'sd1 <<< (SH_ROW - 1));
  localparam acc_t RND_COL = acc_t'(64'sd1 <<< (SH_COL - 1));
  localparam smp_t RND_DC  = smp_t'(1 <<< (PASS1_BITS - 1));

  function automatic acc_t mac2(smp_t a, int ca, smp_t b, int cb);
    return acc_t'(a) * acc_t'(ca) + acc_t'(b) * acc_t'(cb);
  endfunction

  function automatic smp_t descale(acc_t v, logic col);
    acc_t r;
    r = col ? (v + RND_COL) >>> SH_COL : (v + RND_ROW) >>> SH_ROW;
    if (r > SAT_HI) return smp_t'(SAT_HI);
    if (r < SAT_LO) return smp_t'(SAT_LO);
    return smp_t'(r);
  endfunction

  function automatic smp_t dc_scale(smp_t v, logic col);
    smp_t t;
    t = v + RND_DC;
    return col ? (t >>> PASS1_BITS) : (v <<< PASS1_BITS);
  endfunction

  smp_t x [8];
  smp_t sm_d [4];
  smp_t df_d [4];
  smp_t sm_q [4];
  smp_t df_q [4];
  logic s1_valid, s1_pass;
  logic take;

  assign in_ready = ~rst;
  assign take     = in_valid & in_ready;

  for (genvar i = 0; i < 8; i++) begin : g_unpack
    assign x[i] = smp_t'(in_data[i*SAMPLE_W +: SAMPLE_W]);
  end

  for (genvar i = 0; i < 4; i++) begin : g_bfly
    assign sm_d[i] = x[i] + x[7-i];
    assign df_d[i] = x[i] - x[7-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pass  <= 1'b0;
    end else begin
      s1_valid <= take;
      if (take) s1_pass <= in_pass;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      for (int i = 0; i < 4; i++) begin
        sm_q[i] <= sm_d[i];
        df_q[i] <= df_d[i];
      end
    end
  end

  smp_t t4, t5, t6, t7;
  smp_t e10, e11, e12, e13, z3, z4;
  acc_t z3r, z4r, a1, a2, a3, a5, a6, a7;
  smp_t y [8];
  logic [VEC_W-1:0] y_vec;

  assign t7 = df_q[0];
  assign t6 = df_q[1];
  assign t5 = df_q[2];
  assign t4 = df_q[3];

  assign e10 = sm_q[0] + sm_q[3];
  assign e13 = sm_q[0] - sm_q[3];
  assign e11 = sm_q[1] + sm_q[2];
  assign e12 = sm_q[1] - sm_q[2];

  assign y[0] = dc_scale(e10 + e11, s1_pass);
  assign y[4] = dc_scale(e10 - e11, s1_pass);

  assign a2 = mac2(e13, C0541 + C0765, e12, C0541);
  assign a6 = mac2(e13, C0541, e12, C0541 - C1847);

  assign z3  = t4 + t6;
  assign z4  = t5 + t7;
  assign z3r = mac2(z3, C1175 - C1961, z4, C1175);
  assign z4r = mac2(z3, C1175, z4, C1175 - C0390);

  assign a7 = mac2(t4, C0298 - C0899, t7, -C0899) + z3r;
  assign a5 = mac2(t5, C2053 - C2562, t6, -C2562) + z4r;
  assign a3 = mac2(t5, -C2562, t6, C3072 - C2562) + z3r;
  assign a1 = mac2(t4, -C0899, t7, C1501 - C0899) + z4r;

  assign y[1] = descale(a1, s1_pass);
  assign y[2] = descale(a2, s1_pass);
  assign y[3] = descale(a3, s1_pass);
  assign y[5] = descale(a5, s1_pass);
  assign y[6] = descale(a6, s1_pass);
  assign y[7] = descale(a7, s1_pass);

  for (genvar i = 0; i < 8; i++) begin : g_pack
    assign y_vec[i*SAMPLE_W +: SAMPLE_W] = y[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= y_vec;
    end
  end
endmodule

// File: rtl/fdct8_core_chk.sv
module fdct8_core_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_pass,
  input logic                  s1_valid,
  input logic                  s1_pass,
  input logic                  out_valid,
  input logic [8*SAMPLE_W-1:0] out_data
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R2
  accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> s1_valid);

  // R2
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);

  // R2
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);

  // R9
  pass_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (s1_pass == $past(in_pass)));

  // R4
  row_dc_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_pass) |=>
      (out_data[1:0] == 2'b00 && out_data[4*SAMPLE_W +: 2] == 2'b00));
endmodule

bind fdct8_core fdct8_core_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_pass  (in_pass),
  .s1_valid (s1_valid),
  .s1_pass  (s1_pass),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/test_fdct8_core.sv
module test_fdct8_core;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int VW = 8 * SW;
  localparam int NSTR = 20;

  typedef int vec8_t [8];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_pass = 1'b0;
  logic [VW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [VW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdct8_core i_fdct8_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pass(in_pass), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint w16(longint v);
    return longint'(shortint'(v));
  endfunction

  function automatic longint w32(longint v);
    return longint'(int'(v));
  endfunction

  function automatic longint ds(longint v, bit col);
    int sh;
    longint r;
    sh = col ? 15 : 11;
    r = w32(v + (64'sd1 <<< (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic logic [VW-1:0] mk(vec8_t v);
    logic [VW-1:0] r;
    for (int i = 0; i < 8; i++) r[i*SW +: SW] = SW'(v[i]);
    return r;
  endfunction

  function automatic logic [VW-1:0] ref_dct(logic [VW-1:0] d, bit col);
    longint x [8];
    longint t [8];
    longint o [8];
    longint e10, e11, e12, e13, z3, z4, pr, qr;
    logic [VW-1:0] r;
    for (int i = 0; i < 8; i++) x[i] = longint'(shortint'(d[i*SW +: SW]));
    for (int i = 0; i < 4; i++) begin
      t[i]   = w16(x[i] + x[7-i]);
      t[7-i] = w16(x[i] - x[7-i]);
    end
    e10 = w16(t[0] + t[3]);
    e13 = w16(t[0] - t[3]);
    e11 = w16(t[1] + t[2]);
    e12 = w16(t[1] - t[2]);
    o[0] = w16(e10 + e11);
    o[4] = w16(e10 - e11);
    o[0] = col ? (w16(o[0] + 2) >>> 2) : w16(o[0] * 4);
    o[4] = col ? (w16(o[4] + 2) >>> 2) : w16(o[4] * 4);
    o[2] = ds(w32(e13 * 10703 + e12 * 4433), col);
    o[6] = ds(w32(e13 * 4433 - e12 * 10704), col);
    z3 = w16(t[4] + t[6]);
    z4 = w16(t[5] + t[7]);
    pr = w32(-6436 * z3 + 9633 * z4);
    qr = w32(9633 * z3 + 6437 * z4);
    o[7] = ds(w32(w32(-4927 * t[4] - 7373 * t[7]) + pr), col);
    o[5] = ds(w32(w32(-4176 * t[5] - 20995 * t[6]) + qr), col);
    o[3] = ds(w32(w32(-20995 * t[5] + 4177 * t[6]) + pr), col);
    o[1] = ds(w32(w32(-7373 * t[4] + 4926 * t[7]) + qr), col);
    for (int i = 0; i < 8; i++) r[i*SW +: SW] = SW'(o[i]);
    return r;
  endfunction

  task automatic check1(string tag, longint got, longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [VW-1:0] got, logic [VW-1:0] exp);
    for (int i = 0; i < 8; i++) begin
      n_cmp++;
      if (got[i*SW +: SW] !== exp[i*SW +: SW]) begin
        n_bad++;
        $display("FAIL %s lane %0d: got %0d expected %0d", tag, i,
                 $signed(got[i*SW +: SW]), $signed(exp[i*SW +: SW]));
      end
    end
  endtask

  task automatic send(string tag, logic [VW-1:0] d, bit col, output logic [VW-1:0] got);
    @(negedge clk);
    in_valid = 1'b1;
    in_pass  = col;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check1({tag, " R2 out_valid"}, longint'(out_valid), 1);
    got = out_data;
    check_vec(tag, got, ref_dct(d, col));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check1("R1 out_valid in reset", longint'(out_valid), 0);
    check1("R1 out_data in reset", longint'(out_data != '0), 0);
    check1("R1 in_ready in reset", longint'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check1("R2 in_ready after reset", longint'(in_ready), 1);
    check1("R2 no output without input", longint'(out_valid), 0);
  endtask

  task automatic t_impulse();
    logic [VW-1:0] g;
    send("R7 R10 impulse row", mk('{1, 0, 0, 0, 0, 0, 0, 0}), 1'b0, g);
    check_vec("R10 impulse row hand", g, mk('{4, 6, 5, 5, 4, 3, 2, 1}));
    send("R7 impulse col", mk('{1, 0, 0, 0, 0, 0, 0, 0}), 1'b1, g);
    check_vec("R7 impulse col hand", g, '0);
  endtask

  task automatic t_dc();
    logic [VW-1:0] g;
    send("R4 dc row", mk('{100, 100, 100, 100, 100, 100, 100, 100}), 1'b0, g);
    check_vec("R4 dc row hand", g, mk('{3200, 0, 0, 0, 0, 0, 0, 0}));
    send("R4 dc col", mk('{100, 100, 100, 100, 100, 100, 100, 100}), 1'b1, g);
    check_vec("R4 dc col hand", g, mk('{200, 0, 0, 0, 0, 0, 0, 0}));
  endtask

  task automatic t_patterns();
    logic [VW-1:0] g;
    send("R5 R6 ramp row", mk('{0, 100, 200, 300, 400, 500, 600, 700}), 1'b0, g);
    send("R5 R6 ramp col", mk('{0, 100, 200, 300, 400, 500, 600, 700}), 1'b1, g);
    send("R6 alternating row", mk('{1000, -1000, 1000, -1000, 1000, -1000, 1000, -1000}), 1'b0, g);
    send("R5 mixed col", mk('{-3000, 1200, 77, -15, 4000, -900, 23, 511}), 1'b1, g);
    send("R4 R5 negative col", mk('{-7, -7, -3, -3, -1, -1, -9, -9}), 1'b1, g);
  endtask

  task automatic t_wrap();
    logic [VW-1:0] g;
    send("R3 wrap row", mk('{20000, 0, 0, 0, 0, 0, 0, 20000}), 1'b0, g);
    check1("R3 wrap row lane0", longint'($signed(g[0 +: SW])), 28928);
    send("R3 wrap col", mk('{-20000, 5, 0, 0, 0, 0, 5, -20000}), 1'b1, g);
  endtask

  task automatic t_sat();
    logic [VW-1:0] g;
    send("R8 sat high", mk('{8000, 0, 0, -8000, -8000, 0, 0, 8000}), 1'b0, g);
    check1("R8 sat high lane2", longint'($signed(g[2*SW +: SW])), 32767);
    send("R8 sat low", mk('{-8000, 0, 0, 8000, 8000, 0, 0, -8000}), 1'b0, g);
    check1("R8 sat low lane2", longint'($signed(g[2*SW +: SW])), -32768);
    send("R8 extremes", mk('{32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768}), 1'b0, g);
  endtask

  task automatic t_stream();
    logic [VW-1:0] vs [NSTR];
    bit ps [NSTR];
    int seed;
    seed = 12345;
    for (int k = 0; k < NSTR; k++) begin
      for (int i = 0; i < 8; i++) begin
        seed = seed * 1103515245 + 12345;
        vs[k][i*SW +: SW] = SW'(seed >>> 8);
      end
      ps[k] = (k % 3) != 1;
    end
    for (int k = 0; k < NSTR + 3; k++) begin
      @(negedge clk);
      if (k >= 2 && k < NSTR + 2) begin
        check1("R9 stream out_valid", longint'(out_valid), 1);
        check_vec("R9 stream data", out_data, ref_dct(vs[k-2], ps[k-2]));
      end
      if (k == NSTR + 2) check1("R2 bubble after stream", longint'(out_valid), 0);
      if (k < NSTR) begin
        in_valid = 1'b1;
        in_pass  = ps[k];
        in_data  = vs[k];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_idle();
    logic [VW-1:0] held;
    held = out_data;
    in_data = mk('{9, 9, 9, 9, 9, 9, 9, 9});
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check1("R2 idle out_valid", longint'(out_valid), 0);
    check_vec("R2 idle data held", out_data, held);
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_dc();
    t_patterns();
    t_wrap();
    t_sat();
    t_stream();
    t_idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule